// File: doc/BRIEF.md
# Indirect Register Pointer Access Controller

This block lets a narrow host bus reach a bank of sixteen write registers and sixteen read registers through two bus addresses. The command address is indirect. A write to it while no pointer is held lands in register 0, and the low nibble of that byte names the register that the next command-address access reaches. That next read or write goes to the named register, and then the pointer drops back to zero. The data address reaches the data register directly, without the pointer.

A settling time must pass between loading the pointer and using it. The block counts this time in clock cycles, derived from a nanosecond figure and the clock period. A targeted access that arrives too early is stretched: the block holds `ready` low until the interval has passed, then completes the access.

The register bank is outside the block. The block drives a write strobe, an address and write data toward the bank. It drives a read address and a read strobe, and it passes the bank's read value back to the host.

Top module: `ptr_reg_access`

## Requirements
- R1: After reset no pointer is held, `ready` is high, `reg_we` and `reg_re` are low, and `rdata` is 0.
- R2: A command-address write (`a_sel`=0) while no pointer is held writes the whole byte to write register 0. If bits [3:0] of the byte are nonzero, they become the pointer.
- R3: A command-address write whose bits [3:0] are zero writes register 0 and leaves no pointer held, so the next command-address access again reaches register 0.
- R4: A command-address read while no pointer is held returns read register 0 with no wait and leaves no pointer held.
- R5: With a pointer held, a command-address write puts the byte into the write register the pointer names.
- R6: With a pointer held, a command-address read returns the read register the pointer names, and `reg_re` pulses with `reg_raddr` equal to the pointer.
- R7: After a targeted access completes, the pointer is cleared, so the next command-address access reaches register 0.
- R8: A targeted access completes no earlier than GAP_CYC = ceil(MIN_GAP_NS / CLK_NS) clock edges after the pointer write completed (125 by default). An earlier request sees `ready` low and completes exactly on that edge. A later request completes without wait.
- R9: A data-address access (`a_sel`=1) reaches register DATA_IDX (8 by default) for read or write with no wait. It neither clears the pointer nor restarts the recovery count.
- R10: When `cs` is low, or when neither `rd` nor `wr` is high, `reg_we` and `reg_re` stay low and no register changes. If `rd` and `wr` are both high, the cycle is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| a_sel | input | 1 | 0 = command (indirect) address, 1 = data register address |
| rd | input | 1 | Read strobe, held until ready |
| wr | input | 1 | Write strobe, held until ready |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while a read completes, else 0 |
| ready | output | 1 | Low while an early targeted access is stretched |
| reg_we | output | 1 | Bank write strobe |
| reg_waddr | output | 4 | Bank write address |
| reg_wdata | output | 8 | Bank write data |
| reg_re | output | 1 | Bank read strobe (pulses on a completed read) |
| reg_raddr | output | 4 | Bank read address |
| reg_rdata | input | 8 | Bank read value for reg_raddr |

## Verification
A pointer that fails to clear shows up on the very next command-address access: that access reaches a stale register instead of register 0, which appears on `reg_waddr` or in `rdata`. A pointer that never arms shows up on the following access, which goes to register 0 without a wait. An off-by-one in the recovery count moves the completion edge of an early access by one cycle. The bench measures that edge against the pointer write to the exact cycle, with and without data-address traffic in between.

// File: rtl/ptr_reg_pkg.sv
package ptr_reg_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } ptr_state_t;

  // Recovery interval in clock edges, rounded up, never below one.
  function automatic int gap_cycles(input int min_ns, input int clk_ns);
    int c;
    c = (min_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // Register reached by an access: data port is direct, command port uses pointer.
  function automatic logic [3:0] pick_target(input logic data_port, input logic held,
                                             input logic [3:0] ptr, input logic [3:0] data_idx);
    if (data_port) return data_idx;
    else if (held) return ptr;
    else           return 4'd0;
  endfunction

endpackage

// File: rtl/ptr_reg_fsm.sv
module ptr_reg_fsm
  import ptr_reg_pkg::*;
#(
  parameter int AW      = 4,
  parameter int GAP_CYC = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [AW-1:0] load_val,
  input  logic          hit,
  output logic          armed,
  output logic [AW-1:0] ptr,
  output logic          guard_done
);

  localparam int GW = $clog2(GAP_CYC + 1);

  ptr_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_req) begin
          state_q <= ST_ARMED;
          ptr     <= load_val;
        end
        ST_ARMED: if (hit) begin
          state_q <= ST_IDLE;
          ptr     <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign armed = (state_q == ST_ARMED);

  generate
    if (GAP_CYC <= 1) begin : g_no_guard
      assign guard_done = 1'b1;
    end else begin : g_guard
      logic [GW-1:0] guard_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           guard_q <= '0;
        else if (load_req && !armed)          guard_q <= GW'(GAP_CYC - 1);
        else if (guard_q != '0)               guard_q <= guard_q - 1'b1;
      end
      assign guard_done = (guard_q == '0);
    end
  endgenerate

endmodule

// File: rtl/ptr_reg_decode.sv
module ptr_reg_decode
  import ptr_reg_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int DATA_IDX = 8
) (
  input  logic          acc_ok,
  input  logic          a_sel,
  input  logic          wr,
  input  logic          armed,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] tgt,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] rdata
);

  assign tgt       = pick_target(a_sel, armed, ptr, AW'(DATA_IDX));
  assign reg_we    = acc_ok & wr;
  assign reg_re    = acc_ok & ~wr;
  assign reg_wdata = wdata;
  assign rdata     = reg_re ? reg_rdata : '0;

endmodule

// File: rtl/ptr_reg_access.sv
module ptr_reg_access
  import ptr_reg_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int MIN_GAP_NS = 500,
  parameter int CLK_NS     = 4,
  parameter int DATA_IDX   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          a_sel,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ready,
  output logic          reg_we,
  output logic [AW-1:0] reg_waddr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_re,
  output logic [AW-1:0] reg_raddr,
  input  logic [DW-1:0] reg_rdata
);

  localparam int GAP_CYC = gap_cycles(MIN_GAP_NS, CLK_NS);

  // Named internal events
  logic          req;
  logic          cmd_req;
  logic          acc_ok;
  logic          cmd_go;
  logic          load_req;
  logic          hit;
  logic          armed;
  logic          guard_done;
  logic [AW-1:0] ptr;
  logic [AW-1:0] tgt;

  assign req      = cs & (rd | wr);
  assign cmd_req  = req & ~a_sel;
  assign ready    = ~(cmd_req & armed & ~guard_done);
  assign acc_ok   = req & ready;
  assign cmd_go   = acc_ok & ~a_sel;
  assign load_req = cmd_go & wr & ~armed & (wdata[AW-1:0] != '0);
  assign hit      = cmd_go & armed;

  ptr_reg_fsm #(.AW(AW), .GAP_CYC(GAP_CYC)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .load_val  (wdata[AW-1:0]),
    .hit       (hit),
    .armed     (armed),
    .ptr       (ptr),
    .guard_done(guard_done)
  );

  ptr_reg_decode #(.AW(AW), .DW(DW), .DATA_IDX(DATA_IDX)) u_dec (
    .acc_ok   (acc_ok),
    .a_sel    (a_sel),
    .wr       (wr),
    .armed    (armed),
    .ptr      (ptr),
    .wdata    (wdata),
    .reg_rdata(reg_rdata),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .tgt      (tgt),
    .reg_wdata(reg_wdata),
    .rdata    (rdata)
  );

  assign reg_waddr = tgt;
  assign reg_raddr = tgt;

endmodule

// File: rtl/ptr_reg_access_chk.sv
module ptr_reg_access_chk #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int GAP_CYC  = 125,
  parameter int DATA_IDX = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          a_sel,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] wdata,
  input logic          ready,
  input logic          reg_we,
  input logic          reg_re,
  input logic [AW-1:0] reg_waddr,
  input logic          armed,
  input logic [AW-1:0] ptr
);

  localparam int CW = $clog2(GAP_CYC + 1);

  logic          acc;
  logic          ptr_wr;
  logic [CW-1:0] gap_cnt;

  assign acc    = cs & (rd | wr) & ready;
  assign ptr_wr = acc & wr & ~a_sel & ~armed & (wdata[AW-1:0] != '0);

  // Independent count of edges since the pointer write, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              gap_cnt <= '0;
    else if (ptr_wr)                         gap_cnt <= CW'(1);
    else if (armed && gap_cnt < CW'(GAP_CYC)) gap_cnt <= gap_cnt + 1'b1;
  end

  a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> ready);

  a_r2_pointer_arms: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (armed && ptr == $past(wdata[AW-1:0])));

  a_r3_zero_nibble_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && !a_sel && !armed && wdata[AW-1:0] == '0) |=> !armed);

  a_r5_write_to_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr && !a_sel && armed) |-> (reg_we && reg_waddr == ptr));

  a_r7_pointer_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !a_sel && armed) |=> !armed);

  a_r8_gap_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !a_sel && armed) |-> gap_cnt >= CW'(GAP_CYC));

  a_r8_early_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd || wr) && !a_sel && armed && gap_cnt < CW'(GAP_CYC)) |-> !ready);

  a_r9_data_keeps_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && (rd || wr) && a_sel) |=> (armed == $past(armed)));

  a_r9_data_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && a_sel) |-> ready);

  a_r10_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && (rd || wr)) |-> (!reg_we && !reg_re));

endmodule

bind ptr_reg_access ptr_reg_access_chk #(
  .AW(AW), .DW(DW), .GAP_CYC(GAP_CYC), .DATA_IDX(DATA_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .a_sel(a_sel), .rd(rd), .wr(wr),
  .wdata(wdata), .ready(ready), .reg_we(reg_we), .reg_re(reg_re),
  .reg_waddr(reg_waddr), .armed(armed), .ptr(ptr)
);

// File: tb/test_ptr_reg_access.sv
module test_ptr_reg_access;

  localparam int GAP = (500 + 4 - 1) / 4;  // 125 edges

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, a_sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, reg_wdata, reg_rdata;
  logic       ready, reg_we, reg_re;
  logic [3:0] reg_waddr, reg_raddr;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0] wbank [16];

  logic [7:0] l_rdata;
  logic       l_we, l_re;
  logic [3:0] l_addr;
  int         l_done;
  int         t0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (reg_we) wbank[reg_waddr] <= reg_wdata;

  function automatic logic [7:0] rval(input logic [3:0] a);
    return 8'h5A ^ {a, ~a};
  endfunction
  assign reg_rdata = rval(reg_raddr);

  ptr_reg_access i_ptr_reg_access (
    .clk(clk), .rst_n(rst_n), .cs(cs), .a_sel(a_sel), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .ready(ready), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic asel, input logic do_wr, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; a_sel = asel; wr = do_wr; rd = !do_wr; wdata = d;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    l_rdata = rdata; l_we = reg_we; l_re = reg_re;
    l_addr = do_wr ? reg_waddr : reg_raddr; l_done = cyc;
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 ready", ready, 1);
    chk("R1 reg_we", reg_we, 0);
    chk("R1 reg_re", reg_re, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_idle_read;
    bus(1'b0, 1'b0, 8'h00);
    chk("R4 read reg0", l_rdata, rval(4'd0));
    chk("R4 strobe", l_re, 1);
    t0 = l_done;
    bus(1'b0, 1'b0, 8'h00);
    chk("R4 stays idle addr", l_addr, 0);
    chk("R4 no wait", l_done - t0, 1);
  endtask

  task automatic t_zero_nibble;
    bus(1'b0, 1'b1, 8'hA0);
    chk("R3 reg0 written", wbank[0], 8'hA0);
    t0 = l_done;
    bus(1'b0, 1'b0, 8'h00);
    chk("R3 next hits reg0", l_rdata, rval(4'd0));
    chk("R3 no wait", l_done - t0, 1);
  endtask

  task automatic t_early_write;
    bus(1'b0, 1'b1, 8'h35);
    chk("R2 reg0 gets byte", wbank[0], 8'h35);
    t0 = l_done;
    bus(1'b0, 1'b1, 8'h77);
    chk("R8 stretched to gap", l_done - t0, GAP);
    chk("R5 target addr", l_addr, 5);
    chk("R5 target data", wbank[5], 8'h77);
    chk("R5 reg0 untouched", wbank[0], 8'h35);
    t0 = l_done;
    bus(1'b0, 1'b0, 8'h00);
    chk("R7 cleared addr", l_addr, 0);
    chk("R7 cleared data", l_rdata, rval(4'd0));
    chk("R7 no wait", l_done - t0, 1);
  endtask

  task automatic t_late_read;
    bus(1'b0, 1'b1, 8'h0C);
    t0 = l_done;
    idle(200);
    bus(1'b0, 1'b0, 8'h00);
    chk("R8 late no wait", l_done - t0, 201);
    chk("R6 read target", l_rdata, rval(4'd12));
    chk("R6 strobe addr", l_addr, 12);
    chk("R6 strobe", l_re, 1);
  endtask

  task automatic t_partial_wait;
    bus(1'b0, 1'b1, 8'hF9);
    t0 = l_done;
    idle(100);
    bus(1'b0, 1'b1, 8'h3C);
    chk("R8 partial wait", l_done - t0, GAP);
    chk("R5 partial target", wbank[9], 8'h3C);
  endtask

  task automatic t_data_port;
    bus(1'b0, 1'b1, 8'h03);
    t0 = l_done;
    bus(1'b1, 1'b1, 8'hD1);
    chk("R9 data write", wbank[8], 8'hD1);
    chk("R9 data no wait", l_done - t0, 1);
    bus(1'b1, 1'b0, 8'h00);
    chk("R9 data read", l_rdata, rval(4'd8));
    bus(1'b0, 1'b1, 8'h44);
    chk("R9 count not restarted", l_done - t0, GAP);
    chk("R9 pointer kept", wbank[3], 8'h44);
    bus(1'b0, 1'b0, 8'h00);
    chk("R7 cleared after data", l_addr, 0);
  endtask

  task automatic t_quiet_bus;
    logic seen;
    seen = 1'b0;
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; wdata = 8'hEE;
    repeat (3) begin #1; seen = seen | reg_we | reg_re; @(negedge clk); end
    wr = 1'b0; cs = 1'b1;
    repeat (3) begin #1; seen = seen | reg_we | reg_re; @(negedge clk); end
    cs = 1'b0;
    chk("R10 no strobes", seen, 0);
    chk("R10 reg0 kept", wbank[0], 8'h03);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b1; wdata = 8'h60; #1;
    chk("R10 rd+wr is write", reg_we, 1);
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0; wr = 1'b0;
    chk("R10 rd+wr data", wbank[0], 8'h60);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) wbank[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_idle_read;
    t_zero_nibble;
    t_early_write;
    t_late_read;
    t_partial_wait;
    t_data_port;
    t_quiet_bus;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule